// File: doc/BRIEF.md
# Bit-Serial Coupling Field Update Lanes

This block holds the coupling state of a fully connected spin annealer. It keeps one lane per spin. Lane `j` stores the coupling weights between spin `j` and every spin `i`. It also stores a running local field, which is the weighted sum of the neighbouring spins that a flip decision reads. When an outside controller decides that spin `i` now holds a new state, it sends one update command. Every lane then applies the matching coupling weight to its own field, and all lanes do this in the same clocks.

The arithmetic is bit-serial. On acceptance each lane copies its weight into a shift register in one cycle, inverting it when the new state is 0. It then adds that register into the field shift register one bit per clock, LSB first, using a single carry flop. This makes the cost per lane one full adder. The latency equals the field width, which is set by parameters.

The same block has a load port for the initial weights and fields, and a read port that returns the field of any lane. Every command interface is valid/ready. A command transfers on a clock edge where both `valid` and `ready` are high. The block lowers every ready while an update runs. An update request that is pending also lowers the load and read readies, so the update takes priority. A source must hold its command until it is accepted. The read response has no back-pressure: it is valid for exactly one cycle, and the consumer must take it then.

Top module: `spin_field_lanes`

## Requirements
- R1: After reset every stored weight and every field is zero. `upd_ready`, `ld_ready` and `rd_req_ready` are high, and `upd_done` and `rd_rsp_valid` are low.
- R2: A load with `ld_field`=0 writes `ld_data[COEF_W-1:0]` as the weight of lane `ld_lane` toward spin `ld_col`. A load with `ld_field`=1 writes all of `ld_data` as the field of lane `ld_lane`.
- R3: A read accepted on one edge gives `rd_rsp_valid` high for exactly the next cycle, with `rd_rsp_data` equal to that lane's field. Back-to-back reads give back-to-back responses.
- R4: An update with `upd_state`=1 adds, in every lane j, the weight toward spin `upd_idx` to the field. The weight is sign-extended to FIELD_W = COEF_W + log2(NUM_LANES) bits, in two's complement.
- R5: An update with `upd_state`=0 subtracts the sign-extended weight from the field of every lane.
- R6: The lane whose index equals `upd_idx` keeps its field, whatever weight is stored on its diagonal.
- R7: For an update accepted on edge k, `upd_done` is high only in the cycle after edge k+1+FIELD_W, and for one cycle. `upd_ready` is high again in that same cycle.
- R8: From the accepting edge until `upd_done` rises, `upd_ready`, `ld_ready` and `rd_req_ready` are low. Commands offered in that time change no weight, no field and no response.
- R9: While `upd_valid` is high, `ld_ready` and `rd_req_ready` are low.
- R10: Field arithmetic wraps modulo 2^FIELD_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Update command valid |
| upd_ready | output | 1 | Update command ready (idle) |
| upd_idx | input | IDX_W | Index of the spin that changed |
| upd_state | input | 1 | New state of that spin (1 adds, 0 subtracts) |
| upd_done | output | 1 | One-cycle pulse at the end of an update |
| ld_valid | input | 1 | Load command valid |
| ld_ready | output | 1 | Load command ready |
| ld_field | input | 1 | 0 loads a weight, 1 loads a field |
| ld_lane | input | IDX_W | Target lane |
| ld_col | input | IDX_W | Weight column (spin index), used when ld_field is 0 |
| ld_data | input | FIELD_W | Load value |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request ready |
| rd_lane | input | IDX_W | Lane to read |
| rd_rsp_valid | output | 1 | Read response valid, one cycle |
| rd_rsp_data | output | FIELD_W | Field value of the requested lane |

## Verification
The hardest case to reach from the ports is a command that arrives while the serial adders are part way through their bits. The bench raises a stray update, a weight load and a read in the early shift cycles of a running update. All three must leave no trace. The bench confirms this through later read results, which would show a changed weight or field, and through the absence of any extra response. Wrap-around and the most negative weight are reached by loading a field close to the positive limit, together with extreme weights, before the updates that would overflow it.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PREP  = 2'd1,
    PH_SHIFT = 2'd2
  } phase_e;
endpackage

// File: rtl/spf_bit_adder.sv
module spf_bit_adder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);
  assign sum  = a ^ b ^ cin;
  assign cout = (a & b) | (a & cin) | (b & cin);
endmodule

// File: rtl/spf_seq.sv
module spf_seq #(
  parameter int FIELD_W = 19,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             start_dir,
  output logic             busy,
  output logic             prep,
  output logic             step,
  output logic             done,
  output logic [IDX_W-1:0] sel_idx,
  output logic             dir
);
  import spf_pkg::*;

  localparam int CNT_W = $clog2(FIELD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FIELD_W - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] bit_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      done      <= 1'b0;
      sel_idx   <= '0;
      dir       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_PREP;
            sel_idx <= start_idx;
            dir     <= start_dir;
          end
        end
        PH_PREP: begin
          phase_q   <= PH_SHIFT;
          bit_cnt_q <= '0;
        end
        PH_SHIFT: begin
          if (bit_cnt_q == LAST_BIT) begin
            phase_q <= PH_IDLE;
            done    <= 1'b1;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase_q != PH_IDLE);
  assign prep = (phase_q == PH_PREP);
  assign step = (phase_q == PH_SHIFT);
endmodule

// File: rtl/spf_lane.sv
module spf_lane #(
  parameter int NUM_LANES = 8,
  parameter int COEF_W    = 16,
  parameter int FIELD_W   = 19,
  parameter int IDX_W     = 3,
  parameter int LANE_ID   = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               coef_we,
  input  logic [IDX_W-1:0]   coef_col,
  input  logic [COEF_W-1:0]  coef_wdata,
  input  logic               field_we,
  input  logic [FIELD_W-1:0] field_wdata,
  input  logic               prep,
  input  logic [IDX_W-1:0]   sel_col,
  input  logic               add_dir,
  input  logic               step,
  output logic [FIELD_W-1:0] field_q
);
  localparam int GUARD_W = FIELD_W - COEF_W;

  logic [COEF_W-1:0]  coef_mem [NUM_LANES];
  logic [COEF_W-1:0]  picked;
  logic [FIELD_W-1:0] picked_ext;
  logic [FIELD_W-1:0] coef_sr;
  logic [FIELD_W-1:0] field_sr;
  logic               carry_q;
  logic               sum_bit;
  logic               carry_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_LANES; k++) coef_mem[k] <= '0;
    end else if (coef_we) begin
      coef_mem[coef_col] <= coef_wdata;
    end
  end

  // the own spin contributes nothing to its own field
  assign picked     = (sel_col == IDX_W'(LANE_ID)) ? '0 : coef_mem[sel_col];
  assign picked_ext = {{GUARD_W{picked[COEF_W-1]}}, picked};

  spf_bit_adder u_fa (
    .a    (field_sr[0]),
    .b    (coef_sr[0]),
    .cin  (carry_q),
    .sum  (sum_bit),
    .cout (carry_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_sr <= '0;
      coef_sr  <= '0;
      carry_q  <= 1'b0;
    end else if (field_we) begin
      field_sr <= field_wdata;
    end else if (prep) begin
      // subtract = add the inverted weight plus an initial carry of one
      coef_sr <= add_dir ? picked_ext : ~picked_ext;
      carry_q <= ~add_dir;
    end else if (step) begin
      field_sr <= {sum_bit, field_sr[FIELD_W-1:1]};
      coef_sr  <= {1'b0, coef_sr[FIELD_W-1:1]};
      carry_q  <= carry_d;
    end
  end

  assign field_q = field_sr;
endmodule

// File: rtl/spin_field_lanes.sv
module spin_field_lanes #(
  parameter int NUM_LANES = 8,
  parameter int COEF_W    = 16,
  parameter int IDX_W     = $clog2(NUM_LANES),
  parameter int FIELD_W   = COEF_W + $clog2(NUM_LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_valid,
  output logic               upd_ready,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic               upd_state,
  output logic               upd_done,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic               ld_field,
  input  logic [IDX_W-1:0]   ld_lane,
  input  logic [IDX_W-1:0]   ld_col,
  input  logic [FIELD_W-1:0] ld_data,
  input  logic               rd_req_valid,
  output logic               rd_req_ready,
  input  logic [IDX_W-1:0]   rd_lane,
  output logic               rd_rsp_valid,
  output logic [FIELD_W-1:0] rd_rsp_data
);
  logic               busy;
  logic               prep;
  logic               step;
  logic               dir;
  logic [IDX_W-1:0]   sel_idx;
  logic               upd_fire;
  logic               ld_fire;
  logic               rd_fire;
  logic [FIELD_W-1:0] field_bus [NUM_LANES];

  assign upd_ready    = ~busy;
  assign ld_ready     = ~busy & ~upd_valid;
  assign rd_req_ready = ~busy & ~upd_valid;
  assign upd_fire     = upd_valid & upd_ready;
  assign ld_fire      = ld_valid & ld_ready;
  assign rd_fire      = rd_req_valid & rd_req_ready;

  spf_seq #(.FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (upd_fire),
    .start_idx (upd_idx),
    .start_dir (upd_state),
    .busy      (busy),
    .prep      (prep),
    .step      (step),
    .done      (upd_done),
    .sel_idx   (sel_idx),
    .dir       (dir)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic lane_hit;
    assign lane_hit = ld_fire && (ld_lane == IDX_W'(g));
    spf_lane #(
      .NUM_LANES (NUM_LANES),
      .COEF_W    (COEF_W),
      .FIELD_W   (FIELD_W),
      .IDX_W     (IDX_W),
      .LANE_ID   (g)
    ) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .coef_we     (lane_hit & ~ld_field),
      .coef_col    (ld_col),
      .coef_wdata  (ld_data[COEF_W-1:0]),
      .field_we    (lane_hit & ld_field),
      .field_wdata (ld_data),
      .prep        (prep),
      .sel_col     (sel_idx),
      .add_dir     (dir),
      .step        (step),
      .field_q     (field_bus[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end else begin
      rd_rsp_valid <= rd_fire;
      if (rd_fire) rd_rsp_data <= field_bus[rd_lane];
    end
  end
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int FIELD_W = 19
) (
  input logic clk,
  input logic rst_n,
  input logic upd_valid,
  input logic upd_ready,
  input logic upd_done,
  input logic ld_ready,
  input logic rd_req_valid,
  input logic rd_req_ready,
  input logic rd_rsp_valid
);
  localparam int WIN_W = $clog2(FIELD_W + 4);
  localparam logic [WIN_W-1:0] DONE_AT = WIN_W'(FIELD_W + 2);

  logic [WIN_W-1:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else if (upd_valid && upd_ready) win_cnt <= WIN_W'(1);
    else if (upd_done) win_cnt <= '0;
    else if (win_cnt != '0) win_cnt <= win_cnt + 1'b1;
  end

  assert_done_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> (win_cnt == DONE_AT));
  assert_done_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt == DONE_AT) |-> (upd_done && upd_ready));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);
  assert_accept_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> (!upd_ready && !ld_ready && !rd_req_ready));
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_ready |-> (!ld_ready && !rd_req_ready));
  assert_update_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (!ld_ready && !rd_req_ready));
  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> rd_rsp_valid);
  assert_rsp_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |-> $past(rd_req_valid && rd_req_ready));
endmodule

bind spin_field_lanes spf_checker #(.FIELD_W(FIELD_W)) u_spf_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .upd_valid    (upd_valid),
  .upd_ready    (upd_ready),
  .upd_done     (upd_done),
  .ld_ready     (ld_ready),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_rsp_valid (rd_rsp_valid)
);

// File: tb/spin_field_lanes_tb_top.sv
module spin_field_lanes_tb_top;
  localparam int N  = 8;
  localparam int CW = 16;
  localparam int IW = $clog2(N);
  localparam int FW = CW + $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd_valid = 1'b0;
  logic          upd_ready;
  logic [IW-1:0] upd_idx = '0;
  logic          upd_state = 1'b0;
  logic          upd_done;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic          ld_field = 1'b0;
  logic [IW-1:0] ld_lane = '0;
  logic [IW-1:0] ld_col = '0;
  logic [FW-1:0] ld_data = '0;
  logic          rd_req_valid = 1'b0;
  logic          rd_req_ready;
  logic [IW-1:0] rd_lane = '0;
  logic          rd_rsp_valid;
  logic [FW-1:0] rd_rsp_data;

  always #5 clk = ~clk;

  spin_field_lanes #(.NUM_LANES(N), .COEF_W(CW)) dut_i (.*);

  int n_checks = 0;
  int n_fails  = 0;
  logic [CW-1:0] m_coef [N][N];
  logic [FW-1:0] m_field [N];
  logic [FW-1:0] exp_q [$];
  string         tag_q [$];
  logic [31:0]   seed = 32'h1ace_b00c;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    if (rst_n && rd_rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected response", 32'(rd_rsp_data), 32'hdead);
      end else begin
        check(tag_q.pop_front(), 32'(rd_rsp_data), 32'(exp_q.pop_front()));
      end
    end
  end

  function automatic logic [CW-1:0] cpat(int j, int i);
    logic [31:0] h;
    if (i == j) return 16'h1234;
    if (j == 2 && i == 5) return 16'h8000;
    if (j == 3 && i == 5) return 16'h7fff;
    h = 32'(j * 7919 + i * 104729 + 12345) * 32'd2654435761;
    return h[27:12];
  endfunction

  task automatic do_load(logic fld, int lane, int col, logic [FW-1:0] data);
    @(negedge clk);
    ld_valid = 1'b1; ld_field = fld; ld_lane = IW'(lane); ld_col = IW'(col); ld_data = data;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    if (fld) m_field[lane] = data;
    else     m_coef[lane][col] = data[CW-1:0];
  endtask

  task automatic do_read(int lane, string tag);
    @(negedge clk);
    rd_req_valid = 1'b1; rd_lane = IW'(lane);
    exp_q.push_back(m_field[lane]);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_req_valid = 1'b0;
  endtask

  task automatic read_all(string tag);
    for (int j = 0; j < N; j++) do_read(j, tag);
    @(negedge clk);
  endtask

  // update with stray commands offered during the serial phase
  task automatic do_update(int idx, logic st);
    logic [FW-1:0] w;
    @(negedge clk);
    upd_valid = 1'b1; upd_idx = IW'(idx); upd_state = st;
    #1;
    check("R9 ld_ready low with update pending", 32'(ld_ready), 0);
    check("R9 rd_req_ready low with update pending", 32'(rd_req_ready), 0);
    @(posedge clk); #1;
    upd_valid = 1'b0;
    for (int k = 0; k <= FW + 2; k++) begin
      @(negedge clk);
      if (k <= FW) begin
        check("R7 no early done", 32'(upd_done), 0);
        check("R8 upd_ready low while busy", 32'(upd_ready), 0);
        check("R8 ld_ready low while busy", 32'(ld_ready), 0);
      end else if (k == FW + 1) begin
        check("R7 done pulse", 32'(upd_done), 1);
        check("R7 ready with done", 32'(upd_ready), 1);
      end else begin
        check("R7 done single", 32'(upd_done), 0);
      end
      if (k == 1) begin
        upd_valid = 1'b1; upd_idx = IW'((idx + 1) % N); upd_state = ~st;
        ld_valid = 1'b1; ld_field = 1'b0; ld_lane = 0; ld_col = IW'(idx); ld_data = 19'h0_5a5a;
        rd_req_valid = 1'b1; rd_lane = 0;
      end else if (k == 3) begin
        upd_valid = 1'b0; ld_valid = 1'b0; rd_req_valid = 1'b0;
      end
    end
    for (int j = 0; j < N; j++) begin
      if (j != idx) begin
        w = {{(FW-CW){m_coef[j][idx][CW-1]}}, m_coef[j][idx]};
        m_field[j] = st ? (m_field[j] + w) : (m_field[j] - w);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 upd_ready", 32'(upd_ready), 1);
    check("R1 ld_ready", 32'(ld_ready), 1);
    check("R1 rd_req_ready", 32'(rd_req_ready), 1);
    check("R1 upd_done", 32'(upd_done), 0);
    check("R1 rd_rsp_valid", 32'(rd_rsp_valid), 0);
    for (int j = 0; j < N; j++) begin
      m_field[j] = '0;
      for (int i = 0; i < N; i++) m_coef[j][i] = '0;
    end
    read_all("R1 field zero");
    // zero weights: an update leaves fields at zero
    do_update(4, 1'b1);
    read_all("R1 weights zero");

    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++) do_load(1'b0, j, i, FW'(cpat(j, i)));
    for (int j = 0; j < N; j++) do_load(1'b1, j, 0, FW'(j * 1000 - 3500));
    read_all("R2 field load");

    do_update(5, 1'b1);
    read_all("R4 add incl R6 self lane");
    do_update(5, 1'b0);
    read_all("R5 subtract incl R6 self lane");
    do_update(0, 1'b0);
    read_all("R5 subtract spin 0");
    do_update(7, 1'b1);
    read_all("R4 add spin 7");

    // wrap: lane 3 near positive limit, weight toward 5 is 0x7fff
    do_load(1'b1, 3, 0, FW'((1 << (FW - 1)) - 5));
    do_load(1'b1, 2, 0, FW'(1 << (FW - 1)));
    do_update(5, 1'b1);
    read_all("R10 wrap on add");
    do_update(5, 1'b0);
    do_update(5, 1'b0);
    read_all("R10 wrap on subtract");

    for (int t = 0; t < 16; t++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      do_update(int'(seed[15:13]), seed[20]);
      read_all(seed[20] ? "R4 mixed add" : "R5 mixed subtract");
    end

    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule